// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Slice

This block holds four lookup elements that share one configuration bus and one mode select. Each element keeps a 64-bit truth table and runs in one of three modes. It can evaluate a single function of its six selector inputs. It can split its table into two 32-bit halves that both read the same five low selector inputs, which gives two outputs. It can also turn the low half of its table into a 32-stage shift register, with the five low selector inputs choosing which stage appears on the main output.

In shift mode the four registers can be joined end to end. Each element's oldest bit then feeds the next element, which forms one 128-stage delay line whose far end leaves the slice on `chain_out`. Tables are loaded through a parallel write port, one element per write-enable bit. The port is ignored while the slice is shifting. Anything loaded or shifted in can be read back through the function outputs in the lookup modes.

Top module: `fraclut_slice`

## Requirements
- R1: After reset every table bit is 0, so with the slice in single mode `o6` and `o5` are 0 for every selector value.
- R2: With `mode_sel` 2'b00 (single), `o6[n]` is table bit `sel` of element n, where `sel` is `lut_in[6n+5:6n]` and bit 0 of the slice is input 1. `o5[n]` is table bit `{0, sel[4:0]}`.
- R3: With `mode_sel` 2'b01 (dual), `o6[n]` is table bit `32 + sel[4:0]` and `o5[n]` is table bit `sel[4:0]`. `sel[5]` has no effect on either output.
- R4: Dual mode gives two unrelated functions on separate inputs: a 3-input function on `sel[2:0]` held in the upper half, and a 2-input function on `sel[4:3]` held in the lower half.
- R5: Outside shift mode, a high `cfg_we[n]` at a rising edge loads `cfg_data` into element n. Elements whose enable is low keep their contents.
- R6: With `mode_sel` 2'b10 (shift), `cfg_we` has no effect, and table bits 63..32 of every element stay unchanged.
- R7: In shift mode, each rising edge with `sh_en` high moves table bits 30..0 up by one place and loads the element's shift input into bit 0. While `sh_en` is low, nothing changes. `o6[n]` shows table bit `sel[4:0]`, so a bit presented at input k enabled edges ago appears at tap k-1.
- R8: With `cascade` high, element n>0 shifts in element n-1's bit 31 and element 0 shifts in `sh_din[0]`, which makes a 128-stage line. With `cascade` low, element n shifts in `sh_din[n]`. `chain_out` is bit 31 of the last element.
- R9: In shift mode `o5[n]` is bit 31 of element n. `mode_sel` 2'b11 reads the table the same way as single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all tables |
| mode_sel | input | 2 | 00 single, 01 dual, 10 shift, 11 behaves as single |
| cascade | input | 1 | Joins the shift registers end to end in shift mode |
| cfg_we | input | 4 | Per-element table load enable |
| cfg_data | input | 64 | Table contents to load |
| sh_en | input | 1 | Shift enable |
| sh_din | input | 4 | Per-element shift input (only bit 0 is used when cascaded) |
| lut_in | input | 24 | Six selector inputs per element, element n at bits 6n+5..6n |
| o6 | output | 4 | Main output of each element |
| o5 | output | 4 | Second output of each element |
| chain_out | output | 1 | Oldest bit of the last element |

## Verification
On every cycle, the assertions check how the stored tables change. A load copies the bus exactly, idle cycles hold the tables, shift mode never touches the upper halves, each enabled shift moves the low half by one place, and a cascaded element takes its neighbour's tail. The output selection is combinational and cannot be checked by a clocked property. Only the bench can show the dual-mode indexing, that the sixth input is ignored in dual mode, the split into a 3-input and a 2-input function, and the full 128-cycle delay through the joined line. The bench checks these against its own model of the tables and of the line.

// File: rtl/fraclut_pkg.sv
package fraclut_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'b00,
      MODE_DUAL   = 2'b01,
      MODE_SHIFT  = 2'b10,
      MODE_ALT    = 2'b11
   } lut_mode_e;

   function automatic logic mode_is_shift(lut_mode_e m);
      return (m == MODE_SHIFT);
   endfunction

endpackage

// File: rtl/fraclut_store.sv
module fraclut_store #(
   parameter int NUM_IN = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_mode,
   input  logic                 sh_en,
   input  logic                 shin,
   input  logic                 cfg_we,
   input  logic [2**NUM_IN-1:0] cfg_data,
   output logic [2**NUM_IN-1:0] table_q,
   output logic                 tail
);
   localparam int TBL  = 2**NUM_IN;
   localparam int HALF = TBL / 2;

   if (NUM_IN < 3) begin : g_bad_width
      $error("fraclut_store: NUM_IN must be at least 3");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         table_q <= '0;
      end else if (shift_mode) begin
         if (sh_en) table_q[HALF-1:0] <= {table_q[HALF-2:0], shin};
      end else if (cfg_we) begin
         table_q <= cfg_data;
      end
   end

   assign tail = table_q[HALF-1];

   // R5: a load copies the bus exactly
   a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_mode && cfg_we) |=> (table_q == $past(cfg_data)));
   // R5: no enable, no change
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_mode && !cfg_we) |=> $stable(table_q));
   // R6: upper half frozen in shift mode
   a_r6_upper_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      shift_mode |=> $stable(table_q[TBL-1:HALF]));
   // R7: idle shift register holds
   a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_mode && !sh_en) |=> $stable(table_q));
   // R7: one place per enabled edge
   a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_mode && sh_en) |=>
         (table_q[HALF-1:1] == $past(table_q[HALF-2:0])) && (table_q[0] == $past(shin)));

endmodule

// File: rtl/fraclut_read.sv
module fraclut_read
   import fraclut_pkg::*;
#(
   parameter int NUM_IN = 6
) (
   input  logic [2**NUM_IN-1:0] table_q,
   input  logic [NUM_IN-1:0]    sel,
   input  lut_mode_e            mode,
   output logic                 o6,
   output logic                 o5
);
   localparam int TBL  = 2**NUM_IN;
   localparam int HALF = TBL / 2;

   logic [NUM_IN-2:0] lo_idx;
   logic [NUM_IN-1:0] hi_idx;
   logic [NUM_IN-1:0] lo_full;

   assign lo_idx  = sel[NUM_IN-2:0];
   assign hi_idx  = {1'b1, lo_idx};
   assign lo_full = {1'b0, lo_idx};

   always_comb begin
      unique case (mode)
         MODE_DUAL:  o6 = table_q[hi_idx];
         MODE_SHIFT: o6 = table_q[lo_full];
         default:    o6 = table_q[sel];
      endcase
      o5 = mode_is_shift(mode) ? table_q[HALF-1] : table_q[lo_full];
   end

endmodule

// File: rtl/fraclut_slice.sv
module fraclut_slice
   import fraclut_pkg::*;
#(
   parameter int NUM_ELEM = 4,
   parameter int NUM_IN   = 6,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 mode_sel,
   input  logic                       cascade,
   input  logic [NUM_ELEM-1:0]        cfg_we,
   input  logic [2**NUM_IN-1:0]       cfg_data,
   input  logic                       sh_en,
   input  logic [NUM_ELEM-1:0]        sh_din,
   input  logic [NUM_ELEM*NUM_IN-1:0] lut_in,
   output logic [NUM_ELEM-1:0]        o6,
   output logic [NUM_ELEM-1:0]        o5,
   output logic                       chain_out
);
   localparam int TBL = 2**NUM_IN;

   if (NUM_ELEM < 1) begin : g_bad_count
      $error("fraclut_slice: NUM_ELEM must be at least 1");
   end
   if (NUM_IN < 3 || NUM_IN > 8) begin : g_bad_in
      $error("fraclut_slice: NUM_IN must lie in 3..8");
   end

   lut_mode_e             mode;
   logic                  shift_mode;
   logic [TBL-1:0]        tbl  [NUM_ELEM];
   logic [NUM_ELEM-1:0]   tail;
   logic [NUM_ELEM-1:0]   shin;

   assign mode       = lut_mode_e'(mode_sel);
   assign shift_mode = mode_is_shift(mode);

   for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
      if (g == 0 || !CHAIN_EN) begin : g_head
         assign shin[g] = sh_din[g];
      end else begin : g_link
         assign shin[g] = cascade ? tail[g-1] : sh_din[g];
         // R8: cascaded element takes its neighbour's tail
         a_r8_link: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_mode && sh_en && cascade) |=> (tbl[g][0] == $past(tail[g-1])));
      end

      fraclut_store #(.NUM_IN(NUM_IN)) u_store (
         .clk        (clk),
         .rst_n      (rst_n),
         .shift_mode (shift_mode),
         .sh_en      (sh_en),
         .shin       (shin[g]),
         .cfg_we     (cfg_we[g]),
         .cfg_data   (cfg_data),
         .table_q    (tbl[g]),
         .tail       (tail[g])
      );

      fraclut_read #(.NUM_IN(NUM_IN)) u_read (
         .table_q (tbl[g]),
         .sel     (lut_in[g*NUM_IN +: NUM_IN]),
         .mode    (mode),
         .o6      (o6[g]),
         .o5      (o5[g])
      );
   end

   assign chain_out = tail[NUM_ELEM-1];

endmodule

// File: tb/fraclut_slice_tb.sv
module fraclut_slice_tb;
   localparam int NE = 4;
   localparam int NI = 6;
   localparam int NV = 16;
   // vector: {mode[1:0], elem[1:0], sel[5:0]}
   localparam logic [9:0] VEC [NV] = '{
      {2'b00, 2'd0, 6'd0},  {2'b00, 2'd0, 6'd63}, {2'b00, 2'd1, 6'd37},
      {2'b00, 2'd2, 6'd12}, {2'b00, 2'd3, 6'd45}, {2'b00, 2'd3, 6'd6},
      {2'b01, 2'd0, 6'd3},  {2'b01, 2'd0, 6'd35}, {2'b01, 2'd1, 6'd17},
      {2'b01, 2'd1, 6'd49}, {2'b01, 2'd2, 6'd30}, {2'b01, 2'd3, 6'd62},
      {2'b11, 2'd2, 6'd40}, {2'b11, 2'd1, 6'd9},  {2'b11, 2'd3, 6'd58},
      {2'b01, 2'd2, 6'd62}
   };

   logic               clk = 0;
   logic               rst_n = 0;
   logic [1:0]         mode_sel = 2'b00;
   logic               cascade = 0;
   logic [NE-1:0]      cfg_we = '0;
   logic [63:0]        cfg_data = '0;
   logic               sh_en = 0;
   logic [NE-1:0]      sh_din = '0;
   logic [NE*NI-1:0]   lut_in = '0;
   logic [NE-1:0]      o6, o5;
   logic               chain_out;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;
   logic [63:0]  cur [NE];
   logic [127:0] line;
   logic [31:0]  loc [NE];
   logic [7:0]   lf = 8'hA5;

   always #2 clk = ~clk;

   fraclut_slice u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cascade(cascade),
      .cfg_we(cfg_we), .cfg_data(cfg_data), .sh_en(sh_en), .sh_din(sh_din),
      .lut_in(lut_in), .o6(o6), .o5(o5), .chain_out(chain_out)
   );

   function automatic logic [63:0] pat(int n);
      logic [3:0] k = 4'(n + 1);
      return 64'hF0E1_D2C3_B4A5_9687 ^ {16{k}};
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(string req, logic act, logic exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic set_sel(int n, logic [5:0] a);
      lut_in[n*NI +: NI] = a;
   endtask

   task automatic load(int n, logic [63:0] d);
      cfg_we = '0; cfg_we[n] = 1'b1; cfg_data = d;
      tick();
      cfg_we = '0;
      cur[n] = d;
   endtask

   task automatic next_bit(output logic b);
      b = lf[0];
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog: got hang expected finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic b;
      logic [63:0] fn;
      repeat (3) tick();
      rst_n = 1;
      #1;
      // R1: cleared tables
      for (int n = 0; n < NE; n++) begin
         set_sel(n, 6'(17 * n + 40));
         #1;
         chk("R1 o6", o6[n], 1'b0);
         chk("R1 o5", o5[n], 1'b0);
         cur[n] = '0;
      end

      // R5: load element 0 only, element 1 stays clear
      load(0, pat(0));
      set_sel(0, 6'd63); set_sel(1, 6'd63); #1;
      chk("R5 loaded", o6[0], pat(0)[63]);
      chk("R5 untouched", o6[1], 1'b0);
      for (int n = 1; n < NE; n++) load(n, pat(n));

      // R2 R3 R9: vector walk
      for (int v = 0; v < NV; v++) begin
         logic [1:0] m = VEC[v][9:8];
         int e = int'(VEC[v][7:6]);
         logic [5:0] s = VEC[v][5:0];
         logic e6, e5;
         mode_sel = m;
         set_sel(e, s);
         #1;
         e5 = cur[e][{1'b0, s[4:0]}];
         e6 = (m == 2'b01) ? cur[e][{1'b1, s[4:0]}] : cur[e][s];
         chk((m == 2'b01) ? "R3 o6" : (m == 2'b11) ? "R9 alt o6" : "R2 o6", o6[e], e6);
         chk((m == 2'b01) ? "R3 o5" : "R2 o5", o5[e], e5);
      end

      // R3: sixth input ignored in dual mode
      mode_sel = 2'b01;
      set_sel(2, 6'b011110); #1; b = o6[2];
      set_sel(2, 6'b111110); #1;
      chk("R3 a6 ignored", o6[2], b);

      // R4: 3-input xor in upper half, 2-input and in lower half
      for (int i = 0; i < 32; i++) begin
         logic [4:0] ii = 5'(i);
         fn[32 + i] = ^ii[2:0];
         fn[i]      = ii[4] & ii[3];
      end
      mode_sel = 2'b00;
      load(1, fn);
      mode_sel = 2'b01;
      for (int i = 0; i < 32; i++) begin
         logic [4:0] ii = 5'(i);
         set_sel(1, {1'b0, ii}); #1;
         chk("R4 f3", o6[1], ^ii[2:0]);
         chk("R4 f2", o5[1], ii[4] & ii[3]);
      end

      // R6: loads ignored in shift mode
      mode_sel = 2'b10; cascade = 1;
      cfg_we = '1; cfg_data = '1;
      tick();
      cfg_we = '0;
      for (int n = 0; n < NE; n++) line[32*n +: 32] = cur[n][31:0];
      chk("R6 no load", chain_out, line[127]);

      // R7 R8 R9: cascaded line
      set_sel(0, 6'd5);
      for (int c = 0; c < 140; c++) begin
         next_bit(b);
         sh_din[0] = b; sh_en = 1;
         tick();
         line = {line[126:0], b};
         chk("R8 chain", chain_out, line[127]);
         chk("R7 tap5", o6[0], line[5]);
         chk("R9 tail", o5[1], line[63]);
      end
      sh_en = 0;
      repeat (3) tick();
      chk("R7 hold", chain_out, line[127]);
      chk("R7 hold tap", o6[0], line[5]);

      // R8: independent registers
      cascade = 0;
      for (int n = 0; n < NE; n++) loc[n] = line[32*n +: 32];
      for (int c = 0; c < 4; c++) begin
         for (int n = 0; n < NE; n++) begin
            next_bit(b);
            sh_din[n] = b;
            loc[n] = {loc[n][30:0], b};
         end
         sh_en = 1;
         tick();
      end
      sh_en = 0;
      for (int n = 0; n < NE; n++) begin
         set_sel(n, 6'd2); #1;
         chk("R8 split", o6[n], loc[n][2]);
      end
      chk("R8 out", chain_out, loc[NE-1][31]);

      // R6 R7: readback in single mode
      mode_sel = 2'b00;
      for (int n = 0; n < NE; n++) begin
         set_sel(n, 6'd32 + 6'(3 * n + 1)); #1;
         chk("R6 upper", o6[n], cur[n][32 + 3 * n + 1]);
         set_sel(n, 6'(7 * n)); #1;
         chk("R7 lower", o6[n], loc[n][7 * n]);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule